// File: doc/BRIEF.md
# Branch Clock Gating Controller

This block governs a group of branch clocks that all derive from one shared base clock. Each branch has a small configuration word with three controls. The first keeps the branch running. The second makes the branch agree with its bus client before it is gated. The third lets a global power-down request put the branch to sleep. The glitch-free gating cells themselves sit outside the block, so every branch appears here only as a clock-enable output.

A branch is gated when its run control is cleared, or when it is wake-enabled while power-down is requested and no wake event has been seen since power-down began. If the branch has the bus-agreement control set, the block first raises a per-branch disable request. It keeps the clock enable high until the bus side acknowledges, so pending transfers can drain. A wake event, or the power-down request going low, withdraws a pending request and keeps the clock running. Each branch reports whether it is running, and one aggregate output shows whether any branch of the base clock is still alive.

Top module: `bcg_top`

## Requirements
- R1: After reset every configuration word reads 0x1 (running, no handshake, no sleep), all clock enables are 1, no disable request is raised, and the base status is 1.
- R2: Branch i's configuration word sits at word address i. Bit 0 is RUN, bit 1 is the handshake enable and bit 2 is the sleep (wake-up) enable. Bits 31:3 read as zero. Addresses at or above the branch count read as zero, and writes to them change nothing.
- R3: A branch whose RUN bit is cleared and whose handshake enable is clear drops its clock enable on the clock edge after the one that stores the write.
- R4: A branch that must stop and has its handshake enable set raises its disable request while its clock enable stays 1. On the edge that samples the acknowledge high, the clock enable and the request both go to 0.
- R5: While power-down is high, wake-enabled branches stop (through the handshake if it is enabled), and branches without the wake enable keep running.
- R6: A wake event during power-down restarts the wake-enabled branches on the next edge. They stay on until power-down is cleared and raised again.
- R7: Clearing power-down restarts the stopped wake-enabled branches on the next edge.
- R8: A wake event or a power-down clear while a request is pending withdraws the request, and the clock enable stays 1, even if the acknowledge arrives in the same cycle.
- R9: Each branch's running output equals its clock enable. The base status is 1 when at least one branch runs and 0 only when all are stopped.
- R10: Setting RUN again on a stopped branch restores its clock enable on the edge after the write is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | ADDR_W | Word address of a branch configuration word |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| pwr_down | input | 1 | Global power-down request |
| wake_evt | input | 1 | Wake-up event |
| bus_dis_ack | input | NUM_BR | Per-branch bus-idle acknowledge |
| bus_dis_req | output | NUM_BR | Per-branch bus-disable request |
| clk_en | output | NUM_BR | Per-branch gating-cell enable |
| br_running | output | NUM_BR | Per-branch running status |
| base_running | output | 1 | High while any branch runs |

## Verification
The critical collision is the bus-side acknowledge meeting a wake event on the same cycle while a branch's disable request is pending. The bench raises power-down on a branch that has both the handshake and the sleep enable set, waits for the request, and then drives the acknowledge and the wake event together before one edge. The withdrawal must win: after that edge the enable is still 1 and the request is gone. A later cycle with power-down still high confirms that the branch remains awake.

// File: rtl/bcg_pkg.sv
`timescale 1ns/1ps
package bcg_pkg;
    localparam int DATA_W = 32;
    localparam int CFG_W  = 3;

    typedef struct packed {
        logic wake_en;
        logic auto_dis;
        logic run;
    } br_cfg_t;

    typedef enum logic [1:0] {
        ST_ON  = 2'd0,
        ST_REQ = 2'd1,
        ST_OFF = 2'd2
    } br_state_t;

    localparam br_cfg_t CFG_RESET = '{wake_en: 1'b0, auto_dis: 1'b0, run: 1'b1};

    function automatic logic stop_wanted(input br_cfg_t c, input logic sleep);
        return !c.run || (c.wake_en && sleep);
    endfunction
endpackage

// File: rtl/bcg_regs.sv
`timescale 1ns/1ps
module bcg_regs
    import bcg_pkg::*;
#(
    parameter int NUM_BR = 4,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic                     cfg_wr,
    input  logic [DATA_W-1:0]        cfg_wdata,
    output logic [DATA_W-1:0]        cfg_rdata,
    output br_cfg_t [NUM_BR-1:0]     cfg
);
    logic unused_hi;
    assign unused_hi = ^cfg_wdata[DATA_W-1:CFG_W];

    for (genvar i = 0; i < NUM_BR; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[i] <= CFG_RESET;
            end else if (cfg_wr && cfg_addr == ADDR_W'(i)) begin
                cfg[i] <= br_cfg_t'(cfg_wdata[CFG_W-1:0]);
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_BR; i++) begin
            if (cfg_addr == ADDR_W'(i)) begin
                cfg_rdata = {{(DATA_W-CFG_W){1'b0}}, cfg[i]};
            end
        end
    end
endmodule

// File: rtl/bcg_sleep_ctl.sv
`timescale 1ns/1ps
module bcg_sleep_ctl (
    input  logic clk,
    input  logic rst,
    input  logic pwr_down,
    input  logic wake_evt,
    output logic sleep
);
    logic woken_q;

    always_ff @(posedge clk) begin
        if (rst || !pwr_down) begin
            woken_q <= 1'b0;
        end else if (wake_evt) begin
            woken_q <= 1'b1;
        end
    end

    assign sleep = pwr_down && !woken_q && !wake_evt;
endmodule

// File: rtl/bcg_branch.sv
`timescale 1ns/1ps
module bcg_branch
    import bcg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  br_cfg_t cfg,
    input  logic    sleep,
    input  logic    ack,
    output logic    clk_en,
    output logic    req
);
    br_state_t state_q, state_d;
    logic      stop;

    assign stop = stop_wanted(cfg, sleep);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ON: begin
                if (stop) state_d = cfg.auto_dis ? ST_REQ : ST_OFF;
            end
            ST_REQ: begin
                if (!stop)    state_d = ST_ON;
                else if (ack) state_d = ST_OFF;
            end
            ST_OFF: begin
                if (!stop) state_d = ST_ON;
            end
            default: state_d = ST_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ON;
        else     state_q <= state_d;
    end

    assign clk_en = (state_q != ST_OFF);
    assign req    = (state_q == ST_REQ);
endmodule

// File: rtl/bcg_top.sv
`timescale 1ns/1ps
module bcg_top
    import bcg_pkg::*;
#(
    parameter int NUM_BR = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              pwr_down,
    input  logic              wake_evt,
    input  logic [NUM_BR-1:0] bus_dis_ack,
    output logic [NUM_BR-1:0] bus_dis_req,
    output logic [NUM_BR-1:0] clk_en,
    output logic [NUM_BR-1:0] br_running,
    output logic              base_running
);
    br_cfg_t [NUM_BR-1:0] cfg;
    logic                 sleep;

    bcg_regs #(.NUM_BR(NUM_BR), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg(cfg)
    );

    bcg_sleep_ctl u_sleep (
        .clk(clk), .rst(rst), .pwr_down(pwr_down), .wake_evt(wake_evt), .sleep(sleep)
    );

    for (genvar i = 0; i < NUM_BR; i++) begin : g_br
        bcg_branch u_br (
            .clk(clk), .rst(rst), .cfg(cfg[i]), .sleep(sleep),
            .ack(bus_dis_ack[i]), .clk_en(clk_en[i]), .req(bus_dis_req[i])
        );
    end

    assign br_running   = clk_en;
    assign base_running = |br_running;
endmodule

// File: rtl/bcg_checker.sv
`timescale 1ns/1ps
module bcg_checker #(
    parameter int NUM_BR = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [31:0]       cfg_rdata,
    input logic [NUM_BR-1:0] bus_dis_ack,
    input logic [NUM_BR-1:0] bus_dis_req,
    input logic [NUM_BR-1:0] clk_en,
    input logic [NUM_BR-1:0] br_running,
    input logic              base_running
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&clk_en && bus_dis_req == '0 && base_running));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[31:3] == '0);

    p_running_mirror_r9: assert property (@(posedge clk) disable iff (rst)
        br_running == clk_en);

    p_base_any_r9: assert property (@(posedge clk) disable iff (rst)
        base_running == (clk_en != '0));

    for (genvar i = 0; i < NUM_BR; i++) begin : g_chk
        p_req_holds_en_r4: assert property (@(posedge clk) disable iff (rst)
            bus_dis_req[i] |-> clk_en[i]);

        p_no_gate_without_ack_r4: assert property (@(posedge clk) disable iff (rst)
            (bus_dis_req[i] && !bus_dis_ack[i]) |=> clk_en[i]);

        p_req_ends_r8: assert property (@(posedge clk) disable iff (rst)
            $fell(bus_dis_req[i]) |-> (clk_en[i] || $past(bus_dis_ack[i])));
    end
endmodule

bind bcg_top bcg_checker #(.NUM_BR(NUM_BR)) u_chk (
    .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .bus_dis_ack(bus_dis_ack),
    .bus_dis_req(bus_dis_req), .clk_en(clk_en), .br_running(br_running),
    .base_running(base_running)
);

// File: tb/bcg_top_tb_top.sv
`timescale 1ns/1ps
module bcg_top_tb_top;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int NV = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cfg_addr = '0;
    logic          cfg_wr = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          pwr_down = 1'b0;
    logic          wake_evt = 1'b0;
    logic [N-1:0]  bus_dis_ack = '0;
    logic [N-1:0]  bus_dis_req;
    logic [N-1:0]  clk_en;
    logic [N-1:0]  br_running;
    logic          base_running;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bcg_top #(.NUM_BR(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pwr_down(pwr_down),
        .wake_evt(wake_evt), .bus_dis_ack(bus_dis_ack), .bus_dis_req(bus_dis_req),
        .clk_en(clk_en), .br_running(br_running), .base_running(base_running)
    );

    // {addr, write data, expected read-back}
    localparam logic [67:0] VEC [NV] = '{
        {4'd0,  32'hFFFF_FFFF, 32'h0000_0007},
        {4'd1,  32'h0000_0005, 32'h0000_0005},
        {4'd2,  32'h0000_0003, 32'h0000_0003},
        {4'd3,  32'hFFFF_FFF9, 32'h0000_0001},
        {4'd4,  32'h0000_0007, 32'h0000_0000},
        {4'd15, 32'h0000_0001, 32'h0000_0000},
        {4'd1,  32'h0000_0001, 32'h0000_0001}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        cfg_addr  = a;
        cfg_wdata = d;
        cfg_wr    = 1'b1;
        tick();
        cfg_wr    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        for (int a = 0; a < N; a++) begin
            cfg_addr = AW'(a);
            #1;
            chk("R1 cfg reset", cfg_rdata, 32'h1);
        end
        chk("R1 clk_en", 32'(clk_en), 32'hF);
        chk("R1 req", 32'(bus_dis_req), 32'h0);
        chk("R1 base", 32'(base_running), 32'h1);

        // R2: table walk of writes and read-backs
        for (int v = 0; v < NV; v++) begin
            wr(VEC[v][67:64], VEC[v][63:32]);
            cfg_addr = VEC[v][67:64];
            #1;
            chk("R2 readback", cfg_rdata, VEC[v][31:0]);
        end
        chk("R2 clocks untouched", 32'(clk_en), 32'hF);
        for (int a = 0; a < N; a++) wr(AW'(a), 32'h1);
        tick();

        // R3 / R10: plain stop and restart
        wr(0, 32'h0);
        chk("R3 enable held on write edge", 32'(clk_en), 32'hF);
        tick();
        chk("R3 stopped", 32'(clk_en), 32'hE);
        chk("R9 running mirror", 32'(br_running), 32'hE);
        wr(0, 32'h1);
        tick();
        chk("R10 restart", 32'(clk_en), 32'hF);

        // R4: handshake before gating
        wr(1, 32'h2);
        tick();
        chk("R4 req raised", 32'(bus_dis_req), 32'h2);
        chk("R4 enable held", 32'(clk_en), 32'hF);
        tick(); tick();
        chk("R4 waits for ack", 32'(clk_en), 32'hF);
        bus_dis_ack = 4'b0010;
        tick();
        bus_dis_ack = '0;
        chk("R4 gated after ack", 32'(clk_en), 32'hD);
        chk("R4 req dropped", 32'(bus_dis_req), 32'h0);
        wr(1, 32'h1);
        tick();
        chk("R10 restart after handshake", 32'(clk_en), 32'hF);

        // R5..R7: power-down and wake
        wr(2, 32'h5);
        wr(3, 32'h7);
        pwr_down = 1'b1;
        tick();
        chk("R5 plain sleeper off", 32'(clk_en), 32'hB);
        chk("R5 handshake sleeper requests", 32'(bus_dis_req), 32'h8);
        bus_dis_ack = 4'b1000;
        tick();
        bus_dis_ack = '0;
        chk("R5 only sleepers off", 32'(clk_en), 32'h3);
        chk("R9 base with some on", 32'(base_running), 32'h1);
        wake_evt = 1'b1;
        tick();
        wake_evt = 1'b0;
        chk("R6 wake restarts", 32'(clk_en), 32'hF);
        tick(); tick();
        chk("R6 stays awake", 32'(clk_en), 32'hF);
        pwr_down = 1'b0;
        tick();
        pwr_down = 1'b1;
        tick();
        chk("R5 re-sleep", 32'(clk_en), 32'hB);
        pwr_down = 1'b0;
        tick();
        chk("R7 clear restarts", 32'(clk_en), 32'hF);
        chk("R8 pd clear withdraws", 32'(bus_dis_req), 32'h0);

        // R8: ack and wake event in the same cycle
        pwr_down = 1'b1;
        tick();
        chk("R8 req pending", 32'(bus_dis_req), 32'h8);
        bus_dis_ack = 4'b1000;
        wake_evt    = 1'b1;
        tick();
        bus_dis_ack = '0;
        wake_evt    = 1'b0;
        chk("R8 wake beats ack", 32'(clk_en), 32'hF);
        chk("R8 req withdrawn", 32'(bus_dis_req), 32'h0);
        tick();
        chk("R6 still awake", 32'(clk_en), 32'hF);
        pwr_down = 1'b0;
        tick();

        // R9: all stopped
        for (int a = 0; a < N; a++) wr(AW'(a), 32'h0);
        tick();
        chk("R9 all off", 32'(clk_en), 32'h0);
        chk("R9 base zero", 32'(base_running), 32'h0);
        wr(5, 32'h1);
        tick();
        chk("R2 out-of-range write ignored", 32'(clk_en), 32'h0);
        wr(0, 32'h1);
        tick();
        chk("R9 base back", 32'(base_running), 32'h1);
        chk("R10 one branch on", 32'(clk_en), 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule